// File: doc/BRIEF.md
# Activity-Based Auto Standby Controller

This block decides when a small logic device may drop into a low-power standby state. It watches every signal whose movement could change the device's results: the plain inputs, the bidirectional pad values, the device clock (taken in as an ordinary sampled signal) and the internal feedback nets. It runs on a fast sampling clock. When a full idle window of sample cycles passes without a single monitored bit changing, it raises `standby` and freezes the function outputs at the values they had in the last active cycle.

The first monitored change after that ends standby in the same sample cycle. The outputs follow the live function values again, and the idle window starts over. A stopped device clock counts as idleness. A running device clock counts as activity, so a block whose clock is toggling never enters standby.

Top module: `activity_standby_ctrl`

## Requirements
- R1: While `rst` is high, `standby` is low after the first sampling edge and `held_out` equals `fn_in`.
- R2: With the default window of 2, `standby` rises after the third rising edge of `clk` that follows a monitored change presented between edges. It is still low after the first and second such edges.
- R3: A change of any single bit in any monitored group (`pin_in`, `pad_in`, `dev_clk`, `fb_in`) counts as activity.
- R4: While `standby` is high, `held_out` keeps the value `fn_in` had at the last rising edge before `standby` rose. Changes on `fn_in` have no effect on it.
- R5: When a monitored value differs from its previous sample, `standby` goes low in that same sample cycle, before the next edge, and `held_out` follows `fn_in` again.
- R6: After a wake-up, `standby` returns only after another full idle window, counted as in R2.
- R7: A `dev_clk` that changes in every sample cycle keeps `standby` low for as long as it keeps toggling.
- R8: The idle count saturates at the window, so `standby` stays high through any length of idleness (checked over 300 cycles).
- R9: A synchronous reset taken while in standby forces `standby` low at the next edge. After `rst` is released, `standby` returns after 2 edges when no monitored signal changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | IN_W (12) | Monitored input pins |
| pad_in | input | PAD_W (10) | Monitored bidirectional pad values |
| dev_clk | input | 1 | Monitored device clock, sampled as data |
| fb_in | input | FB_W (10) | Monitored internal feedback nets |
| fn_in | input | OUT_W (10) | Live function outputs to pass or freeze |
| held_out | output | OUT_W (10) | Outputs, frozen while in standby |
| standby | output | 1 | High while the device is powered down |

## Verification
A wake-up is combinational. The bench therefore drives each monitored change at a falling edge and checks `standby` and `held_out` 1 ns later, inside that same cycle. Standby entry passes through the sample register and the idle counter. Its result is due after the window plus one rising edge, so the bench checks 1 ns after each of those edges and expects low on the first two and high on the third. The frozen value is due at the edge that raises `standby`. The bench changes `fn_in` only after that edge and compares against the value held before it.

// File: rtl/stdby_pkg.sv
package stdby_pkg;

  // Bits needed to count from 0 up to and including lim.
  function automatic int unsigned count_bits(int unsigned lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

  // Next idle count: cleared on activity, otherwise climbs and stops at lim.
  function automatic int unsigned idle_step(int unsigned cur, logic hit,
                                            int unsigned lim);
    if (hit) return 0;
    if (cur >= lim) return lim;
    return cur + 1;
  endfunction

endpackage

// File: rtl/stdby_edge_scan.sv
module stdby_edge_scan #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] smp,
  output logic         moved
);
  logic [W-1:0] prev_q;
  logic [W-1:0] diff;

  // The previous sample is taken every cycle, reset included.
  always_ff @(posedge clk) prev_q <= smp;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign diff[i] = smp[i] ^ prev_q[i];
  end

  assign moved = |diff;
endmodule

// File: rtl/stdby_idle_timer.sv
module stdby_idle_timer
  import stdby_pkg::*;
#(
  parameter int unsigned LIMIT = 2,
  parameter int unsigned CNT_W = count_bits(LIMIT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= CNT_W'(idle_step(32'(cnt_q), hit, LIMIT));
  end

  assign cnt  = cnt_q;
  assign full = (cnt_q == LIM_V);
endmodule

// File: rtl/stdby_hold.sv
module stdby_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frozen,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] keep_q;

  always_ff @(posedge clk) begin
    if (rst)          keep_q <= '0;
    else if (!frozen) keep_q <= d;
  end

  assign q = frozen ? keep_q : d;
endmodule

// File: rtl/activity_standby_ctrl.sv
module activity_standby_ctrl
  import stdby_pkg::*;
#(
  parameter int unsigned IN_W     = 12,
  parameter int unsigned PAD_W    = 10,
  parameter int unsigned FB_W     = 10,
  parameter int unsigned OUT_W    = 10,
  parameter int unsigned IDLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  pin_in,
  input  logic [PAD_W-1:0] pad_in,
  input  logic             dev_clk,
  input  logic [FB_W-1:0]  fb_in,
  input  logic [OUT_W-1:0] fn_in,
  output logic [OUT_W-1:0] held_out,
  output logic             standby
);
  localparam int unsigned CNT_W = count_bits(IDLE_CYC);

  logic             act_pin, act_pad, act_clk, act_fb;
  logic             act_seen;
  logic [CNT_W-1:0] idle_cnt;
  logic             idle_full;

  stdby_edge_scan #(.W(IN_W))  u_pin (.clk(clk), .smp(pin_in),  .moved(act_pin));
  stdby_edge_scan #(.W(PAD_W)) u_pad (.clk(clk), .smp(pad_in),  .moved(act_pad));
  stdby_edge_scan #(.W(1))     u_clk (.clk(clk), .smp(dev_clk), .moved(act_clk));
  stdby_edge_scan #(.W(FB_W))  u_fb  (.clk(clk), .smp(fb_in),   .moved(act_fb));

  assign act_seen = act_pin | act_pad | act_clk | act_fb;

  stdby_idle_timer #(.LIMIT(IDLE_CYC), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .hit(act_seen), .cnt(idle_cnt), .full(idle_full)
  );

  assign standby = idle_full & ~act_seen;

  stdby_hold #(.W(OUT_W)) u_hold (
    .clk(clk), .rst(rst), .frozen(standby), .d(fn_in), .q(held_out)
  );
endmodule

// File: rtl/activity_standby_chk.sv
module activity_standby_chk #(
  parameter int unsigned OUT_W = 10,
  parameter int unsigned IDLE_CYC = 2,
  parameter int unsigned CNT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             act_seen,
  input logic [CNT_W-1:0] idle_cnt,
  input logic             standby,
  input logic [OUT_W-1:0] held_out
);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(IDLE_CYC);

  a_r1_reset_active: assert property (@(posedge clk) rst |=> !standby);
  a_r5_wake_now: assert property (@(posedge clk) disable iff (rst)
    act_seen |-> !standby);
  a_r3_activity_clears: assert property (@(posedge clk) disable iff (rst)
    act_seen |=> idle_cnt == '0);
  a_r2_count_up: assert property (@(posedge clk) disable iff (rst)
    (!act_seen && idle_cnt < LIM_V) |=> idle_cnt == $past(idle_cnt) + 1'b1);
  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    idle_cnt <= LIM_V);
  a_r4_frozen: assert property (@(posedge clk) disable iff (rst)
    (standby && $past(standby)) |-> $stable(held_out));
endmodule

bind activity_standby_ctrl activity_standby_chk #(
  .OUT_W(OUT_W), .IDLE_CYC(IDLE_CYC), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .act_seen(act_seen), .idle_cnt(idle_cnt),
  .standby(standby), .held_out(held_out)
);

// File: tb/sim_activity_standby_ctrl.sv
`timescale 1ns/1ps
module sim_activity_standby_ctrl;
  localparam int IN_W = 12, PAD_W = 10, FB_W = 10, OUT_W = 10, IDLE = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IN_W-1:0]  pin_in  = '0;
  logic [PAD_W-1:0] pad_in  = '0;
  logic             dev_clk = 1'b0;
  logic [FB_W-1:0]  fb_in   = '0;
  logic [OUT_W-1:0] fn_in   = '0;
  logic [OUT_W-1:0] held_out;
  logic             standby;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  activity_standby_ctrl #(.IN_W(IN_W), .PAD_W(PAD_W), .FB_W(FB_W),
                          .OUT_W(OUT_W), .IDLE_CYC(IDLE)) u0 (
    .clk(clk), .rst(rst), .pin_in(pin_in), .pad_in(pad_in), .dev_clk(dev_clk),
    .fb_in(fb_in), .fn_in(fn_in), .held_out(held_out), .standby(standby)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edge_after();
    @(posedge clk); #1;
  endtask

  // Idle window after a change driven at a falling edge: low, low, then high.
  task automatic check_window(string req);
    for (int k = 1; k <= IDLE; k++) begin
      edge_after();
      check(req, standby, 0);
    end
    edge_after();
    check(req, standby, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    fn_in = 10'h155;
    edge_after(); edge_after();
    check("R1 standby", standby, 0);
    check("R1 output", held_out, 10'h155);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_entry();
    @(negedge clk); pin_in = 12'h001;
    #1 check("R5 wake on change", standby, 0);
    check_window("R2 entry timing");
  endtask

  task automatic t_groups();
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      case (b)
        0: pin_in[IN_W-1]  = ~pin_in[IN_W-1];
        1: pad_in[3]       = ~pad_in[3];
        2: dev_clk         = ~dev_clk;
        default: fb_in[FB_W-1] = ~fb_in[FB_W-1];
      endcase
      #1 check("R3 group activity wakes", standby, 0);
      check_window("R6 rearm window");
    end
  endtask

  task automatic t_hold();
    @(negedge clk); fn_in = 10'h2A5; pad_in[0] = ~pad_in[0];
    check_window("R2 entry before hold");
    @(negedge clk); fn_in = 10'h0F0;
    #1 check("R4 frozen value", held_out, 10'h2A5);
    edge_after(); edge_after();
    check("R4 frozen later", held_out, 10'h2A5);
    @(negedge clk); fb_in[2] = ~fb_in[2];
    #1 check("R5 wake standby", standby, 0);
    check("R5 output follows", held_out, 10'h0F0);
    check_window("R6 after wake");
  endtask

  task automatic t_clock();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); dev_clk = ~dev_clk;
      #1 check("R7 running clock", standby, 0);
    end
    check_window("R7 clock stopped");
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 300; k++) begin
      edge_after();
      if (standby !== 1'b1 || k == 299) check("R8 stays in standby", standby, 1);
    end
  endtask

  task automatic t_reset_in_standby();
    @(negedge clk); rst = 1'b1;
    edge_after();
    check("R9 reset leaves standby", standby, 0);
    @(negedge clk); rst = 1'b0;
    edge_after();
    check("R9 first edge", standby, 0);
    edge_after();
    check("R9 standby again", standby, 1);
  endtask

  initial begin
    t_reset();
    t_entry();
    t_groups();
    t_hold();
    t_clock();
    t_saturate();
    t_reset_in_standby();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule